// File: doc/BRIEF.md
# Headset Jack and Button Debounce Filter

This block cleans up two raw presence levels coming from a headset socket: one that rises when a plug is inserted, and one that indicates a button press or a microphone on the plug. Each level is sampled on a slow strobe. A new level is accepted only after a fixed number of consecutive samples agree with it. Any sample that matches the currently accepted level starts the count over. The strobe comes from a prescaler fed by a one-millisecond tick. Its period follows the selected setting, so the accepted debounce window is always the sample count times the sample period.

The jack lane offers six windows between 16 ms and 512 ms. The button lane offers three windows plus a setting with no debounce at all. The two filtered levels combine into a two-bit headset type code. A detection enable clears both lanes and forces every output to the no-headset state.

Top module: `hs_debounce`

## Requirements
- R1: After reset, jack_flt, btn_flt and hs_type are all 0.
- R2: For jack_sel values 0 to 5, the jack lane samples jack_raw every 2<<jack_sel ms, counting 1 ms ticks from the moment det_en rises. jack_flt takes a new level on the 8th consecutive sample that differs from it, and not before. This gives windows of 16, 32, 64, 128, 256 and 512 ms.
- R3: jack_sel values 6 and 7 behave exactly like value 5 (64 ms samples, 512 ms window).
- R4: For btn_sel values 1, 2 and 3, the button lane samples btn_raw every 1, 2 and 4 ms. btn_flt takes a new level on the 8th consecutive differing sample, giving windows of 8, 16 and 32 ms.
- R5: With btn_sel = 0 and det_en high, btn_flt copies btn_raw one clock later, without waiting for any tick.
- R6: A sample equal to the current filtered level clears the run of differing samples, so a full new run of 8 is needed.
- R7: hs_type is 2'b00 while jack_flt is 0, 2'b01 when jack_flt is 1 and btn_flt is 0, and 2'b11 when both are 1. It never shows 2'b10.
- R8: While det_en is low, the outputs read 0 from the next clock onward, and all filter and prescaler state is cleared. After re-enabling, a full window is needed again.
- R9: Only tick_ms pulses advance the prescalers. Any number of clocks without a tick leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-clock pulse once per millisecond |
| det_en | input | 1 | Detection enable; low clears the block |
| jack_sel | input | 3 | Jack window select (6 and 7 clamp to 5) |
| btn_sel | input | 2 | Button window select (0 = no debounce) |
| jack_raw | input | 1 | Raw jack-insertion level, synchronous |
| btn_raw | input | 1 | Raw button/microphone level, synchronous |
| jack_flt | output | 1 | Debounced jack level |
| btn_flt | output | 1 | Debounced button level |
| hs_type | output | 2 | Headset type: 00 none, 01 no microphone, 11 microphone |

## Verification
The bench builds the block with its default parameters: 8 samples per window, a 64 ms largest jack sample period, and a 4 ms largest button sample period. To keep the 512 ms windows short, the bench issues a 1 ms tick every four clocks. This puts the longest window and both clamped reserved jack codes within reach, each checked one tick before and exactly at the accepting sample. The default sample count also makes it possible to interrupt a run after seven samples and show the restart.

// File: rtl/hs_dbnc_pkg.sv
package hs_dbnc_pkg;

   typedef enum logic [1:0] {
      HS_NONE   = 2'b00,
      HS_NO_MIC = 2'b01,
      HS_RSVD   = 2'b10,
      HS_MIC    = 2'b11
   } hs_type_e;

   // log2 of the jack sample period in ms; reserved codes clamp to the longest
   function automatic logic [2:0] jack_period_log2(input logic [2:0] sel);
      return (sel > 3'd5) ? 3'd6 : sel + 3'd1;
   endfunction

   // log2 of the button sample period in ms; code 0 is the bypass and unused here
   function automatic logic [1:0] btn_period_log2(input logic [1:0] sel);
      return (sel == 2'd0) ? 2'd0 : sel - 2'd1;
   endfunction

endpackage

// File: rtl/hs_dbnc_strobe.sv
module hs_dbnc_strobe #(
   parameter int MAX_LOG = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         en,
   input  logic                         tick,
   input  logic [$clog2(MAX_LOG+1)-1:0] per_log,
   output logic                         stb
);
   localparam int CW = MAX_LOG;

   if (MAX_LOG < 1) begin : g_bad_log
      $error("hs_dbnc_strobe: MAX_LOG must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic [CW:0]   period;
   logic [CW-1:0] lim;

   assign period = (CW+1)'(1) << per_log;
   assign lim    = CW'(period - 1'b1);
   assign stb    = en & tick & (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (!en)      cnt <= '0;
      else if (tick)     cnt <= (cnt >= lim) ? '0 : cnt + 1'b1;
   end

   // R9: without a tick the prescaler does not move
   p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick) |=> $stable(cnt));

   // R9: a strobe restarts the period count
   p_wrap_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stb |=> (cnt == '0));

endmodule

// File: rtl/hs_dbnc_filter.sv
module hs_dbnc_filter #(
   parameter int SAMPLES    = 8,
   parameter bit HAS_BYPASS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic byp,
   input  logic stb,
   input  logic raw,
   output logic flt
);
   localparam int AW = (SAMPLES > 2) ? $clog2(SAMPLES) : 1;
   localparam logic [AW-1:0] LAST = AW'(SAMPLES - 1);

   if (SAMPLES < 2) begin : g_bad_samples
      $error("hs_dbnc_filter: SAMPLES must be at least 2");
   end

   logic          use_byp;
   logic [AW-1:0] agree;

   if (HAS_BYPASS) begin : g_bypass
      assign use_byp = byp;

      // R5: bypass follows the raw level one clock later
      p_bypass_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (en && byp) |=> (flt == $past(raw)));
   end else begin : g_no_bypass
      logic unused_byp;
      assign unused_byp = byp;
      assign use_byp    = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt   <= 1'b0;
         agree <= '0;
      end else if (!en) begin
         flt   <= 1'b0;
         agree <= '0;
      end else if (use_byp) begin
         flt   <= raw;
         agree <= '0;
      end else if (stb) begin
         if (raw == flt) begin
            agree <= '0;
         end else if (agree == LAST) begin
            flt   <= raw;
            agree <= '0;
         end else begin
            agree <= agree + 1'b1;
         end
      end
   end

   // R2: filtered level moves only on a sample strobe
   p_quiet_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !use_byp && !stb) |=> $stable(flt));

   // R6: an incomplete run of differing samples never flips the output
   p_early_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !use_byp && stb && (agree != LAST)) |=> $stable(flt));

endmodule

// File: rtl/hs_debounce.sv
module hs_debounce
   import hs_dbnc_pkg::*;
#(
   parameter int SAMPLES      = 8,
   parameter int JACK_MAX_LOG = 6,
   parameter int BTN_MAX_LOG  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_ms,
   input  logic       det_en,
   input  logic [2:0] jack_sel,
   input  logic [1:0] btn_sel,
   input  logic       jack_raw,
   input  logic       btn_raw,
   output logic       jack_flt,
   output logic       btn_flt,
   output logic [1:0] hs_type
);
   localparam int JLW = $clog2(JACK_MAX_LOG + 1);
   localparam int BLW = $clog2(BTN_MAX_LOG + 1);

   if (JACK_MAX_LOG < 6 || BTN_MAX_LOG < 2) begin : g_bad_range
      $error("hs_debounce: period ranges too small for the select codes");
   end

   logic [JLW-1:0] jack_log;
   logic [BLW-1:0] btn_log;
   logic           jack_stb, btn_stb;
   logic           btn_byp;
   hs_type_e       type_q;

   assign jack_log = JLW'(jack_period_log2(jack_sel));
   assign btn_log  = BLW'(btn_period_log2(btn_sel));
   assign btn_byp  = (btn_sel == 2'd0);

   hs_dbnc_strobe #(.MAX_LOG(JACK_MAX_LOG)) u_jack_stb (
      .clk(clk), .rst_n(rst_n), .en(det_en), .tick(tick_ms),
      .per_log(jack_log), .stb(jack_stb));

   hs_dbnc_strobe #(.MAX_LOG(BTN_MAX_LOG)) u_btn_stb (
      .clk(clk), .rst_n(rst_n), .en(det_en), .tick(tick_ms),
      .per_log(btn_log), .stb(btn_stb));

   hs_dbnc_filter #(.SAMPLES(SAMPLES), .HAS_BYPASS(1'b0)) u_jack_flt (
      .clk(clk), .rst_n(rst_n), .en(det_en), .byp(1'b0),
      .stb(jack_stb), .raw(jack_raw), .flt(jack_flt));

   hs_dbnc_filter #(.SAMPLES(SAMPLES), .HAS_BYPASS(1'b1)) u_btn_flt (
      .clk(clk), .rst_n(rst_n), .en(det_en), .byp(btn_byp),
      .stb(btn_stb), .raw(btn_raw), .flt(btn_flt));

   always_comb begin
      if (!jack_flt)     type_q = HS_NONE;
      else if (!btn_flt) type_q = HS_NO_MIC;
      else               type_q = HS_MIC;
   end
   assign hs_type = type_q;

   // R7: the reserved type code is never reported
   p_type_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hs_type != HS_RSVD);

   // R8: disabling detection reports no headset on the next clock
   p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !det_en |=> (!jack_flt && !btn_flt && hs_type == HS_NONE));

endmodule

// File: tb/hs_debounce_tb_top.sv
module hs_debounce_tb_top;

   typedef struct {
      string      tag;
      logic       j;
      logic       b;
      logic [1:0] t;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_ms = 1'b0;
   logic       det_en = 1'b0;
   logic [2:0] jack_sel = 3'd0;
   logic [1:0] btn_sel = 2'd1;
   logic       jack_raw = 1'b0;
   logic       btn_raw = 1'b0;
   logic       jack_flt, btn_flt;
   logic [1:0] hs_type;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   hs_debounce dut_i (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .det_en(det_en),
      .jack_sel(jack_sel), .btn_sel(btn_sel), .jack_raw(jack_raw),
      .btn_raw(btn_raw), .jack_flt(jack_flt), .btn_flt(btn_flt),
      .hs_type(hs_type));

   // monitor: compare queued expectations just after the falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (jack_flt !== e.j || btn_flt !== e.b || hs_type !== e.t) begin
               n_fail++;
               $display("FAIL %s: jack/btn/type = %b/%b/%b expected %b/%b/%b",
                        e.tag, jack_flt, btn_flt, hs_type, e.j, e.b, e.t);
            end
         end
      end
   end

   task automatic expect_now(input string tag, input logic j, input logic b,
                             input logic [1:0] t);
      exp_t e;
      @(negedge clk);
      e.tag = tag; e.j = j; e.b = b; e.t = t;
      sb_q.push_back(e);
   endtask

   // one tick = 4 clocks, tick high across one rising edge
   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_ms = 1'b1;
         @(negedge clk); tick_ms = 1'b0;
         @(negedge clk);
         @(negedge clk);
      end
   endtask

   // clear the block: both lanes and prescalers start from zero
   task automatic restart(input logic [2:0] js, input logic [1:0] bs,
                          input logic jr, input logic br);
      @(negedge clk); det_en = 1'b0;
      @(negedge clk);
      jack_sel = js; btn_sel = bs; jack_raw = jr; btn_raw = br; det_en = 1'b1;
   endtask

   task automatic jack_window(input string tag, input logic [2:0] js, input int n_ticks);
      restart(js, 2'd1, 1'b1, 1'b0);
      ticks(n_ticks - 1);
      expect_now({tag, " one tick early"}, 1'b0, 1'b0, 2'b00);
      ticks(1);
      expect_now({tag, " at window"}, 1'b1, 1'b0, 2'b01);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      expect_now("R1 reset state", 1'b0, 1'b0, 2'b00);
      rst_n = 1'b1;
      expect_now("R1 after reset release", 1'b0, 1'b0, 2'b00);

      // R2 windows: 8 samples of 2<<sel ms
      jack_window("R2 sel0", 3'd0, 16);
      jack_window("R2 sel2", 3'd2, 64);
      jack_window("R2 sel5", 3'd5, 512);
      // R3 reserved codes clamp to 512 ms
      jack_window("R3 sel6", 3'd6, 512);
      jack_window("R3 sel7", 3'd7, 512);

      // R6: seven differing samples, then one agreeing sample restarts the run
      restart(3'd0, 2'd1, 1'b1, 1'b0);
      ticks(14);
      jack_raw = 1'b0;
      ticks(2);
      jack_raw = 1'b1;
      ticks(14);
      expect_now("R6 run restarted", 1'b0, 1'b0, 2'b00);
      ticks(2);
      expect_now("R6 full new run", 1'b1, 1'b0, 2'b01);

      // R4 button sel1 with jack sel0; R7 type codes
      restart(3'd0, 2'd1, 1'b1, 1'b1);
      ticks(7);
      expect_now("R4 btn sel1 early", 1'b0, 1'b0, 2'b00);
      ticks(1);
      expect_now("R4 R7 btn without jack is type 00", 1'b0, 1'b1, 2'b00);
      ticks(8);
      expect_now("R7 headset with microphone", 1'b1, 1'b1, 2'b11);

      // R4 button sel3: 4 ms samples
      restart(3'd0, 2'd3, 1'b0, 1'b1);
      ticks(31);
      expect_now("R4 btn sel3 early", 1'b0, 1'b0, 2'b00);
      ticks(1);
      expect_now("R4 btn sel3 at window", 1'b0, 1'b1, 2'b00);

      // R5 bypass
      restart(3'd0, 2'd0, 1'b0, 1'b0);
      @(negedge clk); btn_raw = 1'b1;
      expect_now("R5 bypass rise", 1'b0, 1'b1, 2'b00);
      @(negedge clk); btn_raw = 1'b0;
      expect_now("R5 bypass fall", 1'b0, 1'b0, 2'b00);

      // R9: clocks without ticks change nothing
      restart(3'd0, 2'd1, 1'b1, 1'b0);
      repeat (200) @(negedge clk);
      expect_now("R9 no ticks no change", 1'b0, 1'b0, 2'b00);
      ticks(16);
      expect_now("R9 ticks then accept", 1'b1, 1'b0, 2'b01);

      // R8: disable clears outputs and state
      @(negedge clk); det_en = 1'b0;
      expect_now("R8 disabled outputs", 1'b0, 1'b0, 2'b00);
      ticks(20);
      expect_now("R8 ticks while disabled", 1'b0, 1'b0, 2'b00);
      @(negedge clk); det_en = 1'b1;
      ticks(15);
      expect_now("R8 re-enable needs full window", 1'b0, 1'b0, 2'b00);
      ticks(1);
      expect_now("R8 re-enable accepted", 1'b1, 1'b0, 2'b01);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule